// File: doc/BRIEF.md
# Rate-Adaptive Folded Half-Sine Matched Filter

This block is the receive-side pulse-shaping filter of a low-IF baseband whose sampling rate and datapath word length are lowered once a packet's preamble has been processed. It convolves a stream of signed samples with a half-sine pulse. The length of the pulse follows the selected sampling rate, and the precision of the coefficients follows the selected word length. Neither needs any reconfiguration beyond the two select inputs.

The impulse response is symmetric. The filter therefore sums each pair of mirrored delay elements before multiplying, so one multiplier serves two coefficients. Each element of the delay line chooses its next value from three sources: a constant zero, its upstream neighbour, or the filter input. The active span stays centred on the middle of the line at every rate. Elements outside the span are pinned at zero, so the multipliers they feed do not toggle. A one-cycle flush clears all stored history when the datapath is retargeted.

Top module: `halfsine_fold_fir`

## Requirements
- R1: `rate_sel` codes 0 through 7 select 30, 15, 10, 6, 5, 3, 2 and 1 Msps, in that order. The active length L equals the rate in Msps. The filter uses P = ceil(L/2) coefficient pairs over 2P delay elements, at indices 15-P to 14+P of the 30-element line. The newest sample sits in the lowest active index.
- R2: The unquantized coefficient at pulse position m (0 to 2P-1) is computed with a = 2m+1 and b = 4P as round(127 * 16a(b-a) / (5b^2 - 4a(b-a))). This is a rational half-sine approximation with a peak of 127.
- R3: `qdig_sel` carries Q-1, so Q runs from 1 to 8. Each 8-bit two's-complement coefficient keeps its top Q bits and has its low 8-Q bits cleared. With Q=1 every coefficient is zero and `dout` is 0.
- R4: `dout` equals the sum over m < 2P of hq[m]*x[n-m], where x[n] is the newest accepted sample and samples before the last flush count as zero. The result is a 21-bit signed value at full precision that never overflows, including a constant -128 or +127 input at 30 Msps with Q=8.
- R5: A sample accepted at clock edge k, with `flush` low at edges k and k+1, makes `out_valid` high for one cycle after edge k+1, and `dout` carries that sample's result. The select values present at edge k+1 apply. When `out_valid` is low, `dout` holds its value.
- R6: Every delay element outside the active span is loaded with zero at every clock edge, whether or not `in_valid` is high. When the span later grows, those elements contribute zero until shifted data reaches them.
- R7: `flush` clears the delay line, the valid pipeline and `dout` at the next edge. It takes priority over `in_valid` in the same cycle, and that sample is discarded.
- R8: While `rst_n` is low and after its release with no input, `out_valid` and `dout` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of history and output |
| in_valid | input | 1 | Sample strobe |
| din | input | 8 | Signed input sample |
| rate_sel | input | 3 | Sampling-rate code (R1) |
| qdig_sel | input | 3 | Coefficient word length minus one (R3) |
| out_valid | output | 1 | Result strobe |
| dout | output | 21 | Signed filtered sample |

## Verification
The case most likely to go wrong is a flush arriving on the same edge as a sample strobe. The bench raises both in one cycle with a distinctive sample value. It then confirms that no result appears on either of the next two cycles, and that the next lone sample yields only its own product with the first coefficient. A second overlap is a rate change on the same edge as a shift. The bench shrinks the span to one pair and then widens it to the full line in the cycle of the next sample, and predicts by hand which three elements may hold data.

// File: rtl/hsff_pkg.sv
package hsff_pkg;

   typedef enum logic [1:0] {
      SRC_ZERO = 2'd0,
      SRC_PREV = 2'd1,
      SRC_IN   = 2'd2
   } tap_src_t;

   localparam int RATE_CODES = 8;
   localparam int MAX_LEN    = 30;

   // coefficient count per rate code (rate in Msps)
   function automatic int rate_msps(input int code);
      case (code)
         0: return 30;
         1: return 15;
         2: return 10;
         3: return 6;
         4: return 5;
         5: return 3;
         6: return 2;
         default: return 1;
      endcase
   endfunction

   function automatic int pairs_of(input int len);
      return (len + 1) / 2;
   endfunction

   // rational half-sine sample for pair j (j=0 innermost) of a 2*pairs span
   function automatic int hs_coef(input int pairs, input int j, input int amp);
      int a;
      int b;
      int num;
      int den;
      if (j >= pairs) return 0;
      a   = 2 * (pairs - 1 - j) + 1;
      b   = 4 * pairs;
      num = 16 * a * (b - a);
      den = 5 * b * b - 4 * a * (b - a);
      return (2 * amp * num + den) / (2 * den);
   endfunction

endpackage

// File: rtl/hsff_tapline.sv
module hsff_tapline import hsff_pkg::*; #(
   parameter int DATA_W = 8,
   parameter int NCOEF  = 30
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           flush,
   input  logic                           shift,
   input  logic [2:0]                     rate_sel,
   input  logic [DATA_W-1:0]              din,
   output logic [NCOEF-1:0][DATA_W-1:0]   taps
);
   localparam int NPAIR = NCOEF / 2;
   localparam int IDX_W = $clog2(NCOEF + 1);

   logic [IDX_W-1:0] lo_idx;
   logic [IDX_W-1:0] hi_idx;

   always_comb begin
      int p;
      p      = pairs_of(rate_msps(int'(rate_sel)));
      lo_idx = IDX_W'(NPAIR - p);
      hi_idx = IDX_W'(NPAIR - 1 + p);
   end

   for (genvar i = 0; i < NCOEF; i++) begin : g_el
      tap_src_t          src;
      logic [DATA_W-1:0] prev_v;
      logic [DATA_W-1:0] q;

      if (i == 0) begin : g_head
         assign prev_v = '0;
      end else begin : g_body
         assign prev_v = taps[i-1];
      end

      always_comb begin
         if (IDX_W'(i) < lo_idx || IDX_W'(i) > hi_idx) src = SRC_ZERO;
         else if (IDX_W'(i) == lo_idx)                 src = SRC_IN;
         else                                          src = SRC_PREV;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                         q <= '0;
         else if (flush || src == SRC_ZERO)  q <= '0;
         else if (shift)                     q <= (src == SRC_IN) ? din : prev_v;
      end

      assign taps[i] = q;
   end

endmodule

// File: rtl/hsff_coefbank.sv
module hsff_coefbank import hsff_pkg::*; #(
   parameter int COEF_W = 8,
   parameter int NPAIR  = 15,
   parameter int QSEL_W = 3
)(
   input  logic [2:0]                     rate_sel,
   input  logic [QSEL_W-1:0]              qdig_sel,
   output logic [NPAIR-1:0][COEF_W-1:0]   coef
);
   localparam int AMP = 2 ** (COEF_W - 1) - 1;

   logic [COEF_W-1:0] keep_mask;

   always_comb begin
      if (int'(qdig_sel) >= COEF_W - 1) keep_mask = '1;
      else keep_mask = {COEF_W{1'b1}} << (COEF_W - 1 - int'(qdig_sel));
   end

   for (genvar j = 0; j < NPAIR; j++) begin : g_pair
      logic [RATE_CODES-1:0][COEF_W-1:0] row;
      for (genvar r = 0; r < RATE_CODES; r++) begin : g_rate
         localparam int CV = hs_coef(pairs_of(rate_msps(r)), j, AMP);
         assign row[r] = COEF_W'(CV);
      end
      assign coef[j] = row[rate_sel] & keep_mask;
   end

endmodule

// File: rtl/hsff_foldsum.sv
module hsff_foldsum #(
   parameter int DATA_W = 8,
   parameter int COEF_W = 8,
   parameter int NCOEF  = 30,
   parameter int OUT_W  = 21
)(
   input  logic [NCOEF-1:0][DATA_W-1:0]    taps,
   input  logic [NCOEF/2-1:0][COEF_W-1:0]  coef,
   output logic signed [OUT_W-1:0]         acc
);
   localparam int NPAIR  = NCOEF / 2;
   localparam int PRE_W  = DATA_W + 1;
   localparam int PROD_W = PRE_W + COEF_W;

   logic signed [PROD_W-1:0] prod [NPAIR];

   for (genvar j = 0; j < NPAIR; j++) begin : g_fold
      logic signed [PRE_W-1:0] pre;
      assign pre = $signed({taps[NPAIR-1-j][DATA_W-1], taps[NPAIR-1-j]})
                 + $signed({taps[NPAIR+j][DATA_W-1],   taps[NPAIR+j]});
      assign prod[j] = PROD_W'(pre) * PROD_W'($signed(coef[j]));
   end

   always_comb begin
      acc = '0;
      for (int j = 0; j < NPAIR; j++) acc += OUT_W'(prod[j]);
   end

endmodule

// File: rtl/halfsine_fold_fir.sv
module halfsine_fold_fir import hsff_pkg::*; #(
   parameter  int DATA_W = 8,
   parameter  int COEF_W = 8,
   parameter  int NCOEF  = 30,
   localparam int QSEL_W = $clog2(COEF_W),
   localparam int OUT_W  = DATA_W + 1 + COEF_W + $clog2(NCOEF / 2)
)(
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] din,
   input  logic [2:0]               rate_sel,
   input  logic [QSEL_W-1:0]        qdig_sel,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  dout
);
   if (NCOEF % 2 != 0 || NCOEF < MAX_LEN) begin : g_bad_len
      $error("NCOEF must be even and at least the longest pulse");
   end
   if (DATA_W < 2 || COEF_W < 2) begin : g_bad_width
      $error("DATA_W and COEF_W must be at least 2");
   end

   logic [NCOEF-1:0][DATA_W-1:0]   taps;
   logic [NCOEF/2-1:0][COEF_W-1:0] coef;
   logic signed [OUT_W-1:0]        acc;
   logic                           v1;

   hsff_tapline #(.DATA_W(DATA_W), .NCOEF(NCOEF)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .shift    (in_valid),
      .rate_sel (rate_sel),
      .din      (din),
      .taps     (taps)
   );

   hsff_coefbank #(.COEF_W(COEF_W), .NPAIR(NCOEF/2), .QSEL_W(QSEL_W)) u_coef (
      .rate_sel (rate_sel),
      .qdig_sel (qdig_sel),
      .coef     (coef)
   );

   hsff_foldsum #(.DATA_W(DATA_W), .COEF_W(COEF_W), .NCOEF(NCOEF), .OUT_W(OUT_W)) u_sum (
      .taps (taps),
      .coef (coef),
      .acc  (acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v1        <= 1'b0;
         out_valid <= 1'b0;
         dout      <= '0;
      end else if (flush) begin
         v1        <= 1'b0;
         out_valid <= 1'b0;
         dout      <= '0;
      end else begin
         v1        <= in_valid;
         out_valid <= v1;
         if (v1) dout <= acc;
      end
   end

endmodule

// File: rtl/halfsine_fold_fir_chk.sv
module halfsine_fold_fir_chk #(
   parameter int DATA_W = 8,
   parameter int COEF_W = 8,
   parameter int NCOEF  = 30,
   parameter int OUT_W  = 21,
   parameter int QSEL_W = 3
)(
   input logic                    clk,
   input logic                    rst_n,
   input logic                    flush,
   input logic                    in_valid,
   input logic [QSEL_W-1:0]       qdig_sel,
   input logic                    out_valid,
   input logic signed [OUT_W-1:0] dout
);
   localparam longint BOUND = longint'(NCOEF) * (longint'(1) << (DATA_W - 1))
                            * ((longint'(1) << (COEF_W - 1)) - 1);

   AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !flush) ##1 !flush |=> out_valid);                       // R5
   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));                                    // R5
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> ($stable(dout) || $past(flush)));                      // R5
   AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (!out_valid && dout == '0));                                // R7
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (longint'(dout) <= BOUND && longint'(dout) >= -BOUND)); // R4
   AST_Q1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(qdig_sel) == '0) |-> dout == '0);                 // R3

endmodule

bind halfsine_fold_fir halfsine_fold_fir_chk #(
   .DATA_W (DATA_W),
   .COEF_W (COEF_W),
   .NCOEF  (NCOEF),
   .OUT_W  (OUT_W),
   .QSEL_W (QSEL_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .flush     (flush),
   .in_valid  (in_valid),
   .qdig_sel  (qdig_sel),
   .out_valid (out_valid),
   .dout      (dout)
);

// File: tb/sim_halfsine_fold_fir.sv
module sim_halfsine_fold_fir;
   localparam int DW = 8;
   localparam int OW = 21;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] din = '0;
   logic [2:0] rate_sel = 3'd0;
   logic [2:0] qdig_sel = 3'd7;
   logic out_valid;
   logic signed [OW-1:0] dout;

   int n_chk = 0;
   int n_fail = 0;
   int xs [64];
   int lens [8] = '{30, 15, 10, 6, 5, 3, 2, 1};

   always #4 clk = ~clk;

   halfsine_fold_fir u0 (
      .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid), .din(din),
      .rate_sel(rate_sel), .qdig_sel(qdig_sel), .out_valid(out_valid), .dout(dout)
   );

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // R2 coefficient at pulse position m, R3 quantized to q bits
   function automatic longint ref_tap(input int len, input int q, input int m);
      int n2, a, b, num, den, h, step;
      n2 = 2 * ((len + 1) / 2);
      if (m >= n2) return 0;
      a = 2 * m + 1;
      b = 2 * n2;
      num = 16 * a * (b - a);
      den = 5 * b * b - 4 * a * (b - a);
      h = (254 * num + den) / (2 * den);
      step = 1 << (8 - q);
      return longint'(h - (h % step));
   endfunction

   // R4 convolution over samples since the last flush
   function automatic longint exp_at(input int rc, input int qs, input int n);
      longint acc = 0;
      for (int m = 0; m <= n; m++) acc += ref_tap(lens[rc], qs + 1, m) * longint'(xs[n - m]);
      return acc;
   endfunction

   task automatic run_stream(input int rc, input int qs, input int mode, input string tag);
      int ns;
      rate_sel = 3'(rc);
      qdig_sel = 3'(qs);
      flush = 1'b1;
      in_valid = 1'b0;
      @(negedge clk);
      flush = 1'b0;
      ns = 2 * ((lens[rc] + 1) / 2) + 4;
      for (int i = 0; i < ns; i++)
         xs[i] = (mode == 1) ? -128 : (mode == 2) ? 127 :
                 (i % 6 == 1) ? -128 : (i % 6 == 4) ? 127 : int'($urandom_range(255)) - 128;
      for (int i = 0; i < ns + 2; i++) begin
         if (i < 2) check("R7 flush empties pipeline", longint'(out_valid), 0);
         else begin
            check("R5 out_valid per sample", longint'(out_valid), 1);
            check(tag, longint'(dout), exp_at(rc, qs, i - 2));
         end
         if (i < ns) begin
            in_valid = 1'b1;
            din = DW'(xs[i]);
         end else in_valid = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic push_and_look(input int x);
      in_valid = 1'b1;
      din = DW'(x);
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int ns;
      longint held;
      repeat (3) @(negedge clk);
      check("R8 out_valid in reset", longint'(out_valid), 0);
      check("R8 dout in reset", longint'(dout), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 out_valid after release", longint'(out_valid), 0);
      check("R8 dout after release", longint'(dout), 0);

      // R1 R2 R3: every rate code against every word length
      for (int rc = 0; rc < 8; rc++)
         for (int qs = 0; qs < 8; qs++)
            run_stream(rc, qs, 0, "R1 R2 R3 filtered value");

      // R4 extremes at the longest span and full precision
      run_stream(0, 7, 1, "R4 all -128 input");
      run_stream(0, 7, 2, "R4 all +127 input");

      // R5 isolated sample followed by an idle cycle
      run_stream(3, 7, 0, "R5 stream before gap");
      ns = 2 * ((lens[3] + 1) / 2) + 4;
      xs[ns] = -50;
      push_and_look(-50);
      check("R5 out_valid after lone sample", longint'(out_valid), 1);
      check("R5 lone sample value", longint'(dout), exp_at(3, 7, ns));
      held = longint'(dout);
      @(negedge clk);
      check("R5 out_valid idle", longint'(out_valid), 0);
      check("R5 dout held while idle", longint'(dout), held);

      // R6 shrink the span to one pair, then widen it again without flush
      run_stream(0, 7, 2, "R6 fill full line");
      rate_sel = 3'd6;
      push_and_look(-77);
      push_and_look(113);
      check("R6 two-element span", longint'(dout), ref_tap(2, 8, 0) * longint'(-77 + 113));
      rate_sel = 3'd0;
      push_and_look(60);
      check("R6 outer elements stayed zero", longint'(dout),
            ref_tap(30, 8, 0) * 60 + ref_tap(30, 8, 15) * 113 + ref_tap(30, 8, 16) * (-77));

      // R7 flush and sample strobe on the same edge
      run_stream(5, 7, 0, "R7 stream before flush");
      flush = 1'b1;
      in_valid = 1'b1;
      din = 8'sd99;
      @(negedge clk);
      flush = 1'b0;
      in_valid = 1'b0;
      check("R7 out_valid after flush", longint'(out_valid), 0);
      check("R7 dout cleared", longint'(dout), 0);
      @(negedge clk);
      check("R7 flushed sample produced nothing", longint'(out_valid), 0);
      push_and_look(7);
      check("R7 only new sample remains", longint'(dout), ref_tap(3, 8, 0) * 7);

      finish_run();
   end

endmodule